// File: doc/BRIEF.md
# Smart card character transceiver

This block sends and receives single characters over the one-wire, half-duplex I/O line of a smart card. A character is a low start bit, eight data bits with the least significant bit first, and a parity bit. The character is followed by a guard time of high line. Bit times are counted in base clock cycles. A base-clock enable input qualifies each counted cycle, and a 2-bit select sets how many enabled cycles make one elementary time unit (etu). Parity is always generated and always checked. The line is open-drain: the block only pulls it low or lets it go. The pull is the `line_low` output, and the block reads the resolved line on `line_in` at all times.

In the normal character mode, a receiver that detects a parity error pulls the line low for one etu near the end of the character. A transmitter that sees this pulse sends the same character again. In block mode there is no error pulse and no resend, and a bad character only sets the error flag. A timing mode flag raises the transmit-end flag 1.5 etu earlier than usual.

Top module: `sc_char_xcvr`

## Requirements
- R1: The etu length follows `cfg_bcp`: 0 gives 32 enabled base cycles, 1 gives 64, 2 gives 372 and 3 gives 256.
- R2: A transmitted character has these parts in order: a low start bit, `tx_data` with bit 0 first, and the parity bit. Each part lasts one etu. After the parity bit the line is released.
- R3: The parity bit is chosen so that the data and parity bits together hold an even number of ones when `cfg_odd` is 0, and an odd number when `cfg_odd` is 1.
- R4: `tx_end` is 1 after reset. It clears when a transmission is accepted. With `cfg_gsm` at 0, it rises exactly 12.5 etu after the line falls for the start bit.
- R5: With `cfg_gsm` at 1, `tx_end` rises 11.0 etu after the start-bit fall.
- R6: The receiver detects a falling start edge and samples each bit near its midpoint. On good parity it presents the byte on `rx_data` and sets `rx_full`. A pulse on `rx_ack` clears `rx_full` and `rx_perr`.
- R7: With `cfg_blk` at 0, a received parity error sets `rx_perr`, leaves `rx_full` clear, and pulls the line low from 10.5 to 11.5 etu after the start edge.
- R8: With `cfg_blk` at 1, a received parity error sets `rx_perr` and the line is never pulled.
- R9: With `cfg_blk` at 0, a transmitter that finds the line low at 11.0 etu keeps `tx_end` low. It restarts the same character 13.5 etu after the first start edge.
- R10: With `cfg_blk` at 1, the transmitter ignores an error pulse, does not resend, and raises `tx_end` at the normal time.
- R11: Timing counts only cycles with `base_en` high. When the enable is high every other cycle, every interval doubles.
- R12: `tx_start` has no effect while a character is being sent or received.
- R13: After reset the line is released, `tx_end` is 1, and `rx_full` and `rx_perr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_en | input | 1 | Base clock enable; one counted cycle when high |
| cfg_bcp | input | 2 | Base cycles per etu select |
| cfg_odd | input | 1 | 0 even parity, 1 odd parity |
| cfg_blk | input | 1 | Block mode: no error pulse, no resend |
| cfg_gsm | input | 1 | Early transmit-end timing |
| tx_data | input | 8 | Byte to send |
| tx_start | input | 1 | Start a transmission (pulse) |
| tx_end | output | 1 | Transmit-end flag |
| rx_data | output | 8 | Last good received byte |
| rx_full | output | 1 | Good byte waiting |
| rx_perr | output | 1 | Parity error seen |
| rx_ack | input | 1 | Clears rx_full and rx_perr |
| line_in | input | 1 | Resolved line level |
| line_low | output | 1 | Pull the line low when 1 |

## Verification
Transmissions use all four etu selects, so a wrong table entry shows up as a shifted `tx_end` time. Bytes with different ones counts are sent under both parity senses, which separates the even and odd rules. Characters arrive with good and bad parity in both modes, which tells the error pulse apart from the error flag alone. A pulse from the card on the transmit side separates a resend from a normal finish. Runs with a gated base enable and a second start mid-character show whether the enable gates the counts and whether a busy transmitter ignores new starts.

// File: rtl/sc_xcvr_pkg.sv
package sc_xcvr_pkg;
  localparam int ETU_W = 9;
  // phases are counted in half etu from the start edge
  localparam int PH_START_MID = 1;
  localparam int PH_DATA_LO   = 2;
  localparam int PH_DATA_HI   = 19;
  localparam int PH_PAR_END   = 20;
  localparam int PH_ERR_ON    = 21;
  localparam int PH_TX_CHECK  = 22;
  localparam int PH_ERR_OFF   = 23;
  localparam int PH_RX_DONE   = 24;
  localparam int PH_END_NORM  = 25;
  localparam int PH_RESEND    = 27;

  function automatic logic [ETU_W-1:0] etu_clocks(input logic [1:0] sel);
    case (sel)
      2'd0:    return ETU_W'(32);
      2'd1:    return ETU_W'(64);
      2'd2:    return ETU_W'(372);
      default: return ETU_W'(256);
    endcase
  endfunction

  function automatic logic [ETU_W-1:0] half_clocks(input logic [1:0] sel);
    return etu_clocks(sel) >> 1;
  endfunction

  function automatic logic parity_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/sc_etu_timer.sv
module sc_etu_timer
  import sc_xcvr_pkg::*;
#(
  parameter int SUB_W = 8,
  parameter int PH_W  = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            run,
  input  logic            restart,
  input  logic [1:0]      sel,
  output logic [PH_W-1:0] phase,
  output logic            wrap
);
  logic [SUB_W-1:0] sub;
  logic [SUB_W-1:0] half_m1;

  assign half_m1 = SUB_W'(half_clocks(sel) - ETU_W'(1));
  assign wrap    = run && tick && (sub == half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub   <= '0;
      phase <= '0;
    end else if (restart || !run) begin
      sub   <= '0;
      phase <= '0;
    end else if (tick) begin
      if (sub == half_m1) begin
        sub   <= '0;
        phase <= phase + PH_W'(1);
      end else begin
        sub <= sub + SUB_W'(1);
      end
    end
  end

  assert_phase_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (phase <= PH_W'(PH_RESEND)));
endmodule

// File: rtl/sc_tx.sv
module sc_tx
  import sc_xcvr_pkg::*;
#(
  parameter int SUB_W = 8,
  parameter int PH_W  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] sel,
  input  logic       odd,
  input  logic       blk,
  input  logic       gsm,
  input  logic [7:0] data,
  input  logic       start,
  input  logic       hold,
  input  logic       line_in,
  output logic       busy,
  output logic       drive_low,
  output logic       end_flag
);
  logic [8:0]      frame;
  logic            err;
  logic [PH_W-1:0] phase;
  logic            wrap;
  logic [PH_W-1:0] nx;
  logic [3:0]      bidx;
  logic            accept;
  logic            retry_fire;

  assign accept     = start && !busy && !hold;
  assign nx         = phase + PH_W'(1);
  assign bidx       = 4'((nx - PH_W'(PH_DATA_LO)) >> 1);
  assign retry_fire = busy && wrap && (nx == PH_W'(PH_RESEND));

  sc_etu_timer #(.SUB_W(SUB_W), .PH_W(PH_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(busy),
    .restart(accept || retry_fire), .sel(sel), .phase(phase), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      drive_low <= 1'b0;
      end_flag  <= 1'b1;
      err       <= 1'b0;
      frame     <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      frame     <= {parity_of(data, odd), data};
      drive_low <= 1'b1;
      end_flag  <= 1'b0;
      err       <= 1'b0;
    end else if (busy && wrap) begin
      if (nx >= PH_W'(PH_DATA_LO) && nx <= PH_W'(PH_DATA_HI))
        drive_low <= ~frame[bidx];
      if (nx == PH_W'(PH_PAR_END))
        drive_low <= 1'b0;
      if (nx == PH_W'(PH_TX_CHECK)) begin
        if (!blk && !line_in) err <= 1'b1;
        else if (gsm)         end_flag <= 1'b1;
      end
      if (nx == PH_W'(PH_END_NORM) && !err) begin
        busy     <= 1'b0;
        end_flag <= 1'b1;
      end
      if (retry_fire) begin
        drive_low <= 1'b1;
        err       <= 1'b0;
      end
    end
  end

  assert_end_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(end_flag) |-> $past(start));
  assert_blk_noretry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (blk && busy && wrap && nx == PH_W'(PH_TX_CHECK)) |=> !err);
  assert_guard_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase >= PH_W'(PH_PAR_END)) |-> !drive_low);
  assert_err_holds_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !end_flag);
endmodule

// File: rtl/sc_rx.sv
module sc_rx
  import sc_xcvr_pkg::*;
#(
  parameter int SUB_W = 8,
  parameter int PH_W  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] sel,
  input  logic       odd,
  input  logic       blk,
  input  logic       hold,
  input  logic       ack,
  input  logic       line_in,
  output logic       active,
  output logic       drive_low,
  output logic [7:0] data,
  output logic       full,
  output logic       perr
);
  logic [8:0]      sh;
  logic            bad;
  logic [PH_W-1:0] phase;
  logic            wrap;
  logic [PH_W-1:0] nx;
  logic            go;
  logic            parity_ok;

  assign go        = !active && !hold && !line_in;
  assign nx        = phase + PH_W'(1);
  assign parity_ok = (parity_of(sh[7:0], odd) == sh[8]);

  sc_etu_timer #(.SUB_W(SUB_W), .PH_W(PH_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(active),
    .restart(go), .sel(sel), .phase(phase), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      drive_low <= 1'b0;
      data      <= '0;
      full      <= 1'b0;
      perr      <= 1'b0;
      sh        <= '0;
      bad       <= 1'b0;
    end else begin
      if (ack) begin
        full <= 1'b0;
        perr <= 1'b0;
      end
      if (go) begin
        active    <= 1'b1;
        drive_low <= 1'b0;
        bad       <= 1'b0;
      end else if (active && wrap) begin
        if (nx == PH_W'(PH_START_MID) && line_in)
          active <= 1'b0;
        if (nx[0] && nx > PH_W'(PH_START_MID) && nx <= PH_W'(PH_DATA_HI))
          sh <= {line_in, sh[8:1]};
        if (nx == PH_W'(PH_PAR_END)) begin
          bad <= !parity_ok;
          if (parity_ok) begin
            data <= sh[7:0];
            full <= 1'b1;
          end else begin
            perr <= 1'b1;
          end
        end
        if (nx == PH_W'(PH_ERR_ON) && bad && !blk)
          drive_low <= 1'b1;
        if (nx == PH_W'(PH_ERR_OFF))
          drive_low <= 1'b0;
        if (nx == PH_W'(PH_RX_DONE))
          active <= 1'b0;
      end
    end
  end

  assert_blk_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blk |-> !drive_low);
  assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(full) && $rose(perr)));
  assert_pulse_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> active);
endmodule

// File: rtl/sc_char_xcvr.sv
module sc_char_xcvr
  import sc_xcvr_pkg::*;
#(
  parameter int SUB_W = 8,
  parameter int PH_W  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_en,
  input  logic [1:0] cfg_bcp,
  input  logic       cfg_odd,
  input  logic       cfg_blk,
  input  logic       cfg_gsm,
  input  logic [7:0] tx_data,
  input  logic       tx_start,
  output logic       tx_end,
  output logic [7:0] rx_data,
  output logic       rx_full,
  output logic       rx_perr,
  input  logic       rx_ack,
  input  logic       line_in,
  output logic       line_low
);
  logic tx_busy;
  logic tx_low;
  logic rx_active;
  logic rx_low;

  sc_tx #(.SUB_W(SUB_W), .PH_W(PH_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(base_en), .sel(cfg_bcp), .odd(cfg_odd),
    .blk(cfg_blk), .gsm(cfg_gsm), .data(tx_data), .start(tx_start),
    .hold(rx_active), .line_in(line_in), .busy(tx_busy),
    .drive_low(tx_low), .end_flag(tx_end)
  );

  sc_rx #(.SUB_W(SUB_W), .PH_W(PH_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(base_en), .sel(cfg_bcp), .odd(cfg_odd),
    .blk(cfg_blk), .hold(tx_busy), .ack(rx_ack), .line_in(line_in),
    .active(rx_active), .drive_low(rx_low), .data(rx_data),
    .full(rx_full), .perr(rx_perr)
  );

  assign line_low = tx_low | rx_low;

  assert_one_talker_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_busy && rx_active));
  assert_tx_owns_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_low |-> !tx_busy);
endmodule

// File: tb/tb_sc_char_xcvr.sv
`timescale 1ns/1ps
module tb_sc_char_xcvr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_en = 1'b1;
  logic [1:0] cfg_bcp = 2'd0;
  logic       cfg_odd = 1'b0;
  logic       cfg_blk = 1'b0;
  logic       cfg_gsm = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_start = 1'b0;
  logic       tx_end;
  logic [7:0] rx_data;
  logic       rx_full;
  logic       rx_perr;
  logic       rx_ack = 1'b0;
  logic       line_low;
  logic       card_low = 1'b0;
  logic       line_in;
  logic       slow = 1'b0;

  assign line_in = ~(line_low | card_low);

  sc_char_xcvr dut (
    .clk(clk), .rst_n(rst_n), .base_en(base_en), .cfg_bcp(cfg_bcp),
    .cfg_odd(cfg_odd), .cfg_blk(cfg_blk), .cfg_gsm(cfg_gsm),
    .tx_data(tx_data), .tx_start(tx_start), .tx_end(tx_end),
    .rx_data(rx_data), .rx_full(rx_full), .rx_perr(rx_perr), .rx_ack(rx_ack),
    .line_in(line_in), .line_low(line_low)
  );

  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int perr_cnt = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int half_of(input logic [1:0] s);
    case (s)
      2'd0: return 16;
      2'd1: return 32;
      2'd2: return 186;
      default: return 128;
    endcase
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    int c = 0;
    for (int i = 0; i < 8; i++) if (d[i]) c++;
    return logic'(c % 2) ^ odd;
  endfunction

  // base enable: every cycle, or every other cycle when slow
  initial forever begin
    @(negedge clk);
    base_en = slow ? ~base_en : 1'b1;
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (rx_ack) rx_ack = 1'b0;
    else if (rst_n && (rx_full || rx_perr)) begin
      if (rx_full) begin
        if (exp_q.size() == 0) chk(0, "R6 unexpected byte", rx_data, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R6 received byte", rx_data, e);
        end
      end
      if (rx_perr) perr_cnt++;
      rx_ack = 1'b1;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  task automatic tx_send(input logic [7:0] d);
    @(negedge clk);
    tx_data = d;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
  endtask

  // card side receiver; hh = cycles per half etu
  task automatic card_rx(input int hh, input bit nack, output logic [7:0] d,
                         output logic p, output int te_at, output int refall_at);
    te_at = -1;
    refall_at = -1;
    d = '0;
    p = 1'b0;
    while (line_in) @(negedge clk);
    for (int k = 1; k <= 27 * hh; k++) begin
      @(negedge clk);
      for (int b = 0; b < 8; b++) if (k == (3 + 2 * b) * hh) d[b] = line_in;
      if (k == 19 * hh) p = line_in;
      if (nack && k == 21 * hh) card_low = 1'b1;
      if (k == 23 * hh) card_low = 1'b0;
      if (te_at < 0 && tx_end) te_at = k;
      if (k == 27 * hh && !line_in) refall_at = k;
    end
  endtask

  // card side transmitter
  task automatic card_tx(input int hh, input logic [7:0] d, input bit bad,
                         output bit low22, output bit high24);
    logic [9:0] bits;
    bits = {par_bit(d, cfg_odd) ^ bad, d, 1'b0};
    low22 = 1'b0;
    high24 = 1'b0;
    if (!bad) exp_q.push_back(d);
    @(negedge clk);
    for (int b = 0; b < 10; b++) begin
      card_low = ~bits[b];
      repeat (2 * hh) @(negedge clk);
    end
    card_low = 1'b0;
    for (int k = 20 * hh + 1; k <= 30 * hh; k++) begin
      @(negedge clk);
      if (k == 22 * hh) low22 = !line_in;
      if (k == 24 * hh) high24 = line_in;
    end
  endtask

  initial begin
    logic [7:0] d;
    logic p;
    int te, rf, hh, pc;
    bit lo, hi;

    repeat (3) @(negedge clk);
    // R13 reset state
    chk(line_low == 1'b0, "R13 line released", line_low, 0);
    chk(tx_end == 1'b1, "R13 tx_end", tx_end, 1);
    chk(rx_full == 1'b0, "R13 rx_full", rx_full, 0);
    chk(rx_perr == 1'b0, "R13 rx_perr", rx_perr, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 etu table, R2 frame, R3 even parity, R4 normal end time
    for (int s = 0; s < 4; s++) begin
      cfg_bcp = 2'(s);
      hh = half_of(cfg_bcp);
      tx_send(8'hA5 ^ 8'(s));
      card_rx(hh, 1'b0, d, p, te, rf);
      chk(d == (8'hA5 ^ 8'(s)), "R2 tx data", d, 8'hA5 ^ 8'(s));
      chk(p == par_bit(d, 1'b0), "R3 even parity", p, par_bit(d, 1'b0));
      chk(te == 25 * hh, "R1 R4 tx_end time", te, 25 * hh);
      chk(rf == -1, "R4 no resend", rf, -1);
    end

    cfg_bcp = 2'd0;
    hh = 16;
    // R3 odd parity
    cfg_odd = 1'b1;
    tx_send(8'h3C);
    card_rx(hh, 1'b0, d, p, te, rf);
    chk(d == 8'h3C, "R2 tx data odd", d, 8'h3C);
    chk(p == par_bit(8'h3C, 1'b1), "R3 odd parity", p, par_bit(8'h3C, 1'b1));
    cfg_odd = 1'b0;

    // R5 early end
    cfg_gsm = 1'b1;
    tx_send(8'h01);
    card_rx(hh, 1'b0, d, p, te, rf);
    chk(te == 22 * hh, "R5 early tx_end", te, 22 * hh);
    cfg_gsm = 1'b0;

    // R9 resend after error pulse
    tx_send(8'h5A);
    card_rx(hh, 1'b1, d, p, te, rf);
    chk(te == -1, "R9 tx_end held low", te, -1);
    chk(rf == 27 * hh, "R9 resend edge", rf, 27 * hh);
    card_rx(hh, 1'b0, d, p, te, rf);
    chk(d == 8'h5A, "R9 resent data", d, 8'h5A);
    chk(te == 25 * hh, "R9 end after resend", te, 25 * hh);

    // R10 block mode ignores error pulse
    cfg_blk = 1'b1;
    tx_send(8'h77);
    card_rx(hh, 1'b1, d, p, te, rf);
    chk(te == 25 * hh, "R10 normal end", te, 25 * hh);
    chk(rf == -1, "R10 no resend", rf, -1);
    cfg_blk = 1'b0;

    // R12 second start while busy
    tx_send(8'hC3);
    fork
      begin
        repeat (30) @(negedge clk);
        tx_data = 8'h00;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
      end
    join_none
    card_rx(hh, 1'b0, d, p, te, rf);
    chk(d == 8'hC3, "R12 data kept", d, 8'hC3);
    chk(te == 25 * hh, "R12 timing kept", te, 25 * hh);
    chk(line_in == 1'b1, "R12 no new frame", line_in, 1);

    // R6 reception of good bytes under both parities
    card_tx(hh, 8'h00, 1'b0, lo, hi);
    chk(!lo, "R6 no error pulse", lo, 0);
    card_tx(hh, 8'hFF, 1'b0, lo, hi);
    cfg_odd = 1'b1;
    card_tx(hh, 8'h81, 1'b0, lo, hi);
    card_tx(hh, 8'h4E, 1'b0, lo, hi);
    chk(!lo, "R6 odd good no pulse", lo, 0);
    cfg_odd = 1'b0;

    // R7 parity error with pulse
    pc = perr_cnt;
    card_tx(hh, 8'h96, 1'b1, lo, hi);
    chk(lo, "R7 pulse low at 11.0 etu", lo, 1);
    chk(hi, "R7 released at 12.0 etu", hi, 1);
    chk(perr_cnt == pc + 1, "R7 rx_perr", perr_cnt, pc + 1);

    // R8 block mode error flag only
    cfg_blk = 1'b1;
    pc = perr_cnt;
    card_tx(hh, 8'h96, 1'b1, lo, hi);
    chk(!lo, "R8 no pulse", lo, 0);
    chk(perr_cnt == pc + 1, "R8 rx_perr", perr_cnt, pc + 1);
    cfg_blk = 1'b0;

    // R11 gated base enable doubles timing
    slow = 1'b1;
    tx_send(8'h6B);
    card_rx(2 * hh, 1'b0, d, p, te, rf);
    chk(d == 8'h6B, "R11 data slow", d, 8'h6B);
    chk(te >= 50 * hh - 1 && te <= 50 * hh + 1, "R11 end time slow", te, 50 * hh);
    slow = 1'b0;

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all bytes seen", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule